// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a free-running supervisor timer that runs from its own slow clock. A 12-bit down-counter is loaded from a reload register and steps once per tick of a power-of-two prescaler. If software fails to refresh the counter before it runs out, the block emits a one-cycle system reset request and records the event in a sticky status flag.

All control goes through a small register write port. Sixteen-bit code words written to the key register serve three purposes: they unlock the timing configuration, refresh the counter, and start the timer. Once started, the timer cannot be stopped by software. Only an external system reset stops it. The status flag survives that reset, so boot code can find out why the chip restarted.

Top module: `key_watchdog`

## Requirements
- R1: After power-on reset the timer is stopped and locked. `rst_req` and `wdg_flag` are 0, `cfg_div` is 0, and `cfg_reload` and `count` are 0xFFF.
- R2: Writes to the prescaler register (address 1, bits 2:0) and the reload register (address 2, bits 11:0) take effect only while unlocked. Writing 0x5555 to the key register (address 0) unlocks them. While locked, such writes leave `cfg_div` and `cfg_reload` unchanged.
- R3: A key write of any value other than 0x5555, 0xAAAA or 0xCCCC locks the configuration. Writes of 0xAAAA and 0xCCCC leave the lock state unchanged.
- R4: Writing 0xAAAA to the key register loads `count` from the reload value and restarts the prescaler. The next timeout then comes a full period after that write.
- R5: Writing 0xCCCC starts a stopped timer. The first `rst_req` appears (reload+1)·(4<<p) cycles after the start write, where p is the prescaler code clamped to 6. Codes 6 and 7 both divide by 256.
- R6: `rst_req` is high for exactly one cycle. The counter then reloads by itself, and the next pulse follows one full period later while the timer keeps running.
- R7: Once running, no register write stops the timer. Writes of arbitrary keys, a repeated start, or writes to other registers leave `running` at 1.
- R8: A timeout sets `wdg_flag`. The flag stays set through `sys_rst_n`. Writing 1 to bit 0 of address 3 clears it, and so does `por_n`. If a timeout and a clear land in the same cycle, the set wins.
- R9: Asserting `sys_rst_n` stops the timer, locks it and restores the default prescaler and reload values. While stopped, no `rst_req` occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| por_n | input | 1 | Power-on reset, active low; clears everything including the flag |
| sys_rst_n | input | 1 | System reset, active low; stops the timer, keeps the flag |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 key, 1 prescaler, 2 reload, 3 status clear |
| wr_data | input | 16 | Write data |
| rst_req | output | 1 | One-cycle system reset request on timeout |
| wdg_flag | output | 1 | Sticky "reset caused by watchdog" flag |
| running | output | 1 | Timer started |
| unlocked | output | 1 | Configuration writes currently permitted |
| count | output | 12 | Current down-counter value |
| cfg_div | output | 3 | Prescaler code register |
| cfg_reload | output | 12 | Reload register |

## Verification
The bench measures the exact cycle distance from each start or refresh write to the reset pulse. That catches an off-by-one period, such as a counter that fires on reaching zero instead of on the tick after zero, or a prescaler that is not restarted on refresh. It also checks the clamp at the top prescaler codes and the smallest reload value of zero.

The bench probes the lock with stray key values and confirms that refresh and start leave the lock alone. A design that relocked on any key, or never relocked, would let a write land or drop one. It then verifies that the flag survives a system reset but not power-on or an explicit clear, and that a stopped timer stays silent.

// File: rtl/key_watchdog.sv
module key_watchdog #(
  parameter int CNT_W = 12,
  parameter int KEY_W = 16,
  parameter int PR_W = 3,
  parameter int PR_MAX = 6,
  parameter logic [KEY_W-1:0] KEY_UNLOCK = 16'h5555,
  parameter logic [KEY_W-1:0] KEY_FEED = 16'hAAAA,
  parameter logic [KEY_W-1:0] KEY_START = 16'hCCCC
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             sys_rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [KEY_W-1:0] wr_data,
  output logic             rst_req,
  output logic             wdg_flag,
  output logic             running,
  output logic             unlocked,
  output logic [CNT_W-1:0] count,
  output logic [PR_W-1:0]  cfg_div,
  output logic [CNT_W-1:0] cfg_reload
);
  localparam int PRE_W = PR_MAX + 2;

  logic             rst_all;
  logic [PRE_W-1:0] pre_q;
  logic [PR_W-1:0]  pr_eff;
  logic [PRE_W-1:0] div_m1;
  logic             key_wr, is_feed, is_start, do_load, tick, timeout, clr_flag;

  assign rst_all  = por_n & sys_rst_n;
  assign key_wr   = wr_en && wr_addr == 2'd0;
  assign is_feed  = key_wr && wr_data == KEY_FEED;
  assign is_start = key_wr && wr_data == KEY_START;
  assign do_load  = is_feed || (is_start && !running);
  assign pr_eff   = (cfg_div > PR_W'(PR_MAX)) ? PR_W'(PR_MAX) : cfg_div;
  assign div_m1   = PRE_W'((32'd4 << pr_eff) - 32'd1);
  assign tick     = running && !do_load && pre_q == div_m1;
  assign timeout  = tick && count == '0;
  assign clr_flag = wr_en && wr_addr == 2'd3 && wr_data[0];

  always_ff @(posedge clk or negedge rst_all) begin
    if (!rst_all) begin
      unlocked   <= 1'b0;
      cfg_div    <= '0;
      cfg_reload <= '1;
    end else begin
      if (key_wr) begin
        if (wr_data == KEY_UNLOCK) unlocked <= 1'b1;
        else if (wr_data != KEY_FEED && wr_data != KEY_START) unlocked <= 1'b0;
      end
      if (wr_en && unlocked && wr_addr == 2'd1) cfg_div <= wr_data[PR_W-1:0];
      if (wr_en && unlocked && wr_addr == 2'd2) cfg_reload <= wr_data[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_all) begin
    if (!rst_all) begin
      running <= 1'b0;
      count   <= '1;
      pre_q   <= '0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= timeout;
      if (is_start) running <= 1'b1;
      if (do_load) begin
        count <= cfg_reload;
        pre_q <= '0;
      end else if (running) begin
        if (tick) begin
          pre_q <= '0;
          count <= (count == '0) ? cfg_reload : count - 1'b1;
        end else begin
          pre_q <= pre_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) wdg_flag <= 1'b0;
    else if (timeout) wdg_flag <= 1'b1;
    else if (clr_flag) wdg_flag <= 1'b0;
  end

  assert_locked_div_R2: assert property (@(posedge clk) disable iff (!rst_all)
    (wr_en && wr_addr == 2'd1 && !unlocked) |=> $stable(cfg_div));
  assert_locked_reload_R2: assert property (@(posedge clk) disable iff (!rst_all)
    (wr_en && wr_addr == 2'd2 && !unlocked) |=> $stable(cfg_reload));
  assert_feed_load_R4: assert property (@(posedge clk) disable iff (!rst_all)
    (wr_en && wr_addr == 2'd0 && wr_data == KEY_FEED) |=> count == $past(cfg_reload));
  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_all)
    rst_req |=> !rst_req);
  assert_pulse_running_R6: assert property (@(posedge clk) disable iff (!rst_all)
    rst_req |-> running);
  assert_no_stop_R7: assert property (@(posedge clk) disable iff (!rst_all)
    running |=> running);
  assert_flag_set_R8: assert property (@(posedge clk) disable iff (!por_n)
    rst_req |-> wdg_flag);
  assert_stopped_quiet_R9: assert property (@(posedge clk) disable iff (!rst_all)
    !running |=> !rst_req);
endmodule

// File: tb/tb_key_watchdog.sv
module tb_key_watchdog;
  logic clk = 0, por_n = 0, sys_rst_n = 1, wr_en = 0;
  logic [1:0] wr_addr = 0;
  logic [15:0] wr_data = 0;
  logic rst_req, wdg_flag, running, unlocked;
  logic [11:0] count, cfg_reload;
  logic [2:0] cfg_div;
  int checks = 0, fails = 0;

  key_watchdog dut (.clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rst_req(rst_req), .wdg_flag(wdg_flag),
    .running(running), .unlocked(unlocked), .count(count), .cfg_div(cfg_div),
    .cfg_reload(cfg_reload));

  always #10 clk = ~clk;

  function automatic int exp_period(int pr, int rl);
    return (rl + 1) * (4 << ((pr > 6) ? 6 : pr));
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic measure(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!rst_req && n < 20000);
  endtask

  task automatic sysrst();
    @(negedge clk); sys_rst_n = 0;
    @(negedge clk); @(negedge clk); sys_rst_n = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    por_n = 1;
    @(negedge clk);
    chk("R1 running", running, 0);
    chk("R1 unlocked", unlocked, 0);
    chk("R1 rst_req", rst_req, 0);
    chk("R1 flag", wdg_flag, 0);
    chk("R1 div", cfg_div, 0);
    chk("R1 reload", cfg_reload, 12'hFFF);
    chk("R1 count", count, 12'hFFF);

    wr(1, 16'h0005); chk("R2 locked div", cfg_div, 0);
    wr(2, 16'h0123); chk("R2 locked reload", cfg_reload, 12'hFFF);
    wr(0, 16'h5555); chk("R2 unlock", unlocked, 1);
    wr(1, 16'h0002); chk("R2 div write", cfg_div, 2);

    wr(0, 16'h1234); chk("R3 relock", unlocked, 0);
    wr(2, 16'h0055); chk("R3 reload ignored", cfg_reload, 12'hFFF);
    wr(0, 16'h5555); wr(0, 16'hAAAA); chk("R3 feed keeps unlock", unlocked, 1);
    wr(0, 16'hCCCC); chk("R3 start keeps unlock", unlocked, 1);
    sysrst();
    wr(0, 16'h5555); wr(2, 16'h0009); chk("R2 reload write", cfg_reload, 9);

    wr(0, 16'hCCCC);
    chk("R5 running", running, 1);
    chk("R5 count loaded", count, 9);
    measure(n); chk("R5 first period", n, 40);
    chk("R8 flag set", wdg_flag, 1);
    measure(n); chk("R6 auto reload period", n, 40);
    chk("R6 still running", running, 1);

    repeat (20) @(negedge clk);
    wr(0, 16'hAAAA);
    chk("R4 count after feed", count, 9);
    measure(n); chk("R4 period after feed", n, 40);

    wr(0, 16'h0000); wr(0, 16'hFFFF); wr(3, 16'h0000); wr(0, 16'hCCCC);
    chk("R7 running after writes", running, 1);
    measure(n); chk("R7 still times out", (n < 60) ? 1 : 0, 1);

    sysrst();
    chk("R9 stopped", running, 0);
    chk("R8 flag kept over sys reset", wdg_flag, 1);
    chk("R9 div default", cfg_div, 0);
    chk("R9 reload default", cfg_reload, 12'hFFF);
    chk("R9 locked", unlocked, 0);
    n = 0;
    repeat (200) begin @(negedge clk); if (rst_req) n++; end
    chk("R9 no pulse when stopped", n, 0);
    wr(3, 16'h0001); chk("R8 flag cleared", wdg_flag, 0);

    for (int i = 0; i < 13; i++) begin
      int pr, rl;
      if (i == 0) begin pr = 7; rl = 0; end
      else if (i == 1) begin pr = 6; rl = 0; end
      else if (i == 2) begin pr = 0; rl = 0; end
      else begin pr = $urandom % 8; rl = $urandom % 32; end
      sysrst();
      wr(0, 16'h5555); wr(1, 16'(pr)); wr(2, 16'(rl)); wr(0, 16'hCCCC);
      measure(n); chk("R5 period", n, exp_period(pr, rl));
    end
    chk("R8 flag before por", wdg_flag, 1);
    @(negedge clk); por_n = 0; @(negedge clk); por_n = 1; @(negedge clk);
    chk("R8 por clears flag", wdg_flag, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule